// File: doc/BRIEF.md
# Timer Unit Control and Status Register Bank

This block is the shared register bank for a small multi-channel timer unit. It holds four 32-bit state words: channel enable, clock stop, event flag and interrupt mask. Software reaches each word through a read address and two write-only aliases. In the first alias, every one bit written sets the matching state bit. In the second, every one bit written clears it. Software never needs a read-modify-write sequence, and a write to one channel's bits cannot disturb another channel.

Each timer channel delivers two single-cycle event pulses: one when its counter reaches the full (period) value and one when it reaches the half (duty) value. The bank records both in the one flag word. Full events of channel n use bit n and half events use bit n+16. The mask word has the same layout. The bank drives one interrupt line per channel from the unmasked flags. It also drives each channel's enable and clock-stop signals, and a separate stop signal for the watchdog clock.

Top module: `tcu_ctrl_bank`

## Requirements
- R1: After a synchronous reset the enable and flag words read 0, the mask and stop words read 0xFFFFFFFF, every interrupt is low and the watchdog stop output is high.
- R2: A write to a set alias (enable 0x14, flag 0x24, mask 0x34, stop 0x2C) sets each state bit whose written bit is one and leaves all other bits unchanged.
- R3: A write to a clear alias (enable 0x18, flag 0x28, mask 0x38, stop 0x3C) clears each state bit whose written bit is one and leaves all other bits unchanged.
- R4: Reads return the word at enable 0x10, stop 0x1C, flag 0x20 and mask 0x30, with no wait cycle. Writes to these four plain addresses change nothing. Any other address reads 0 and ignores writes.
- R5: A full-event pulse on channel n sets flag bit n, and a half-event pulse on channel n sets flag bit n+16, at the next clock edge.
- R6: When an event and a flag-clear write on the same bit fall in the same cycle, the bit ends set.
- R7: Interrupt n is high when flag bit n is set with mask bit n zero, or when flag bit n+16 is set with mask bit n+16 zero. A mask bit of one blocks its flag.
- R8: Channel n's enable output follows enable bit n and its stop output follows stop bit n, independently of each other. The watchdog stop output follows stop bit 16.
- R9: With no write and no event, no state word changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_full | input | NUM_CH | Per-channel full-match event pulses |
| evt_half | input | NUM_CH | Per-channel half-match event pulses |
| ch_irq | output | NUM_CH | Per-channel masked interrupt |
| ch_enable | output | NUM_CH | Per-channel counter enable |
| ch_stop | output | NUM_CH | Per-channel clock stop |
| wdt_stop | output | 1 | Watchdog clock stop |

## Verification
Software acknowledging a flag through the clear alias and a channel raising a new event on that same bit can fall in the same clock cycle. The bench raises both together by driving a full-flag clear write in the cycle where a full-event pulse arrives. It then reads the flag word back and requires the event bit set and every other cleared bit zero. The interrupt lines are also checked after that cycle, to show that the surviving flag is still subject to its mask.

// File: rtl/tcu_regs_pkg.sv
package tcu_regs_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int HALF_OFS = 16;
    localparam int WDT_BIT  = 16;
    localparam int NUM_REGS = 4;

    typedef enum logic [1:0] {
        RID_EN   = 2'd0,
        RID_STOP = 2'd1,
        RID_FLAG = 2'd2,
        RID_MASK = 2'd3
    } reg_id_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_READ = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } reg_op_e;

    typedef struct packed {
        reg_id_e sel;
        reg_op_e op;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.sel = RID_EN;
        d.op  = OP_NONE;
        unique case (a)
            8'h10: begin d.sel = RID_EN;   d.op = OP_READ; end
            8'h14: begin d.sel = RID_EN;   d.op = OP_SET;  end
            8'h18: begin d.sel = RID_EN;   d.op = OP_CLR;  end
            8'h1C: begin d.sel = RID_STOP; d.op = OP_READ; end
            8'h20: begin d.sel = RID_FLAG; d.op = OP_READ; end
            8'h24: begin d.sel = RID_FLAG; d.op = OP_SET;  end
            8'h28: begin d.sel = RID_FLAG; d.op = OP_CLR;  end
            8'h2C: begin d.sel = RID_STOP; d.op = OP_SET;  end
            8'h30: begin d.sel = RID_MASK; d.op = OP_READ; end
            8'h34: begin d.sel = RID_MASK; d.op = OP_SET;  end
            8'h38: begin d.sel = RID_MASK; d.op = OP_CLR;  end
            8'h3C: begin d.sel = RID_STOP; d.op = OP_CLR;  end
            default: begin d.sel = RID_EN; d.op = OP_NONE; end
        endcase
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] reset_word(input int id);
        if (id == int'(RID_MASK) || id == int'(RID_STOP))
            return '1;
        return '0;
    endfunction

endpackage

// File: rtl/tcu_bus_decode.sv
module tcu_bus_decode
    import tcu_regs_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] set_w [NUM_REGS],
    output logic [DATA_W-1:0] clr_w [NUM_REGS],
    output reg_id_e           rd_sel,
    output logic              rd_hit
);
    reg_dec_t dec;

    always_comb begin
        dec    = decode_addr(addr);
        rd_sel = dec.sel;
        rd_hit = (dec.op == OP_READ);
        for (int r = 0; r < NUM_REGS; r++) begin
            set_w[r] = '0;
            clr_w[r] = '0;
            if (wr_en && dec.sel == reg_id_e'(r)) begin
                if (dec.op == OP_SET) set_w[r] = wdata;
                if (dec.op == OP_CLR) clr_w[r] = wdata;
            end
        end
    end
endmodule

// File: rtl/tcu_w1_reg.sv
module tcu_w1_reg #(
    parameter int            WIDTH   = 32,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_w,
    input  logic [WIDTH-1:0] clr_w,
    input  logic [WIDTH-1:0] hw_set,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= ((q | set_w) & ~clr_w) | hw_set;
    end
endmodule

// File: rtl/tcu_irq_combine.sv
module tcu_irq_combine
    import tcu_regs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [DATA_W-1:0] flag,
    input  logic [DATA_W-1:0] mask,
    output logic [NUM_CH-1:0] irq
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic full_hit, half_hit;
        assign full_hit = flag[n] & ~mask[n];
        assign half_hit = flag[n+HALF_OFS] & ~mask[n+HALF_OFS];
        assign irq[n]   = full_hit | half_hit;
    end
endmodule

// File: rtl/tcu_ctrl_bank.sv
module tcu_ctrl_bank
    import tcu_regs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] evt_full,
    input  logic [NUM_CH-1:0] evt_half,
    output logic [NUM_CH-1:0] ch_irq,
    output logic [NUM_CH-1:0] ch_enable,
    output logic [NUM_CH-1:0] ch_stop,
    output logic              wdt_stop
);
    localparam int MAX_CH = HALF_OFS;

    initial begin
        if (NUM_CH < 1 || NUM_CH > MAX_CH)
            $error("NUM_CH out of range");
    end

    logic [DATA_W-1:0] set_w [NUM_REGS];
    logic [DATA_W-1:0] clr_w [NUM_REGS];
    logic [DATA_W-1:0] reg_q [NUM_REGS];
    logic [DATA_W-1:0] evt_word;
    reg_id_e           rd_sel;
    logic              rd_hit;

    tcu_bus_decode u_dec (
        .wr_en  (bus_wr_en),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .set_w  (set_w),
        .clr_w  (clr_w),
        .rd_sel (rd_sel),
        .rd_hit (rd_hit)
    );

    always_comb begin
        evt_word = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            evt_word[n]          = evt_full[n];
            evt_word[n+HALF_OFS] = evt_half[n];
        end
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [DATA_W-1:0] hw;
        if (r == int'(RID_FLAG)) begin : g_evt
            assign hw = evt_word;
        end else begin : g_noevt
            assign hw = '0;
        end
        tcu_w1_reg #(
            .WIDTH   (DATA_W),
            .RST_VAL (reset_word(r))
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .set_w  (set_w[r]),
            .clr_w  (clr_w[r]),
            .hw_set (hw),
            .q      (reg_q[r])
        );
    end

    logic [DATA_W-1:0] en_q, stop_q, flag_q, mask_q;
    assign en_q   = reg_q[RID_EN];
    assign stop_q = reg_q[RID_STOP];
    assign flag_q = reg_q[RID_FLAG];
    assign mask_q = reg_q[RID_MASK];

    assign bus_rdata = rd_hit ? reg_q[rd_sel] : '0;

    tcu_irq_combine #(.NUM_CH(NUM_CH)) u_irq (
        .flag (flag_q),
        .mask (mask_q),
        .irq  (ch_irq)
    );

    assign ch_enable = en_q[NUM_CH-1:0];
    assign ch_stop   = stop_q[NUM_CH-1:0];
    assign wdt_stop  = stop_q[WDT_BIT];
endmodule

// File: rtl/tcu_ctrl_bank_chk.sv
module tcu_ctrl_bank_chk
    import tcu_regs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_en,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_CH-1:0] evt_full,
    input logic [NUM_CH-1:0] evt_half,
    input logic [NUM_CH-1:0] ch_irq,
    input logic [NUM_CH-1:0] ch_enable,
    input logic              wdt_stop,
    input logic [31:0]       en_q,
    input logic [31:0]       stop_q,
    input logic [31:0]       flag_q,
    input logic [31:0]       mask_q
);
    logic [31:0] evt_vec;
    always_comb begin
        evt_vec = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            evt_vec[n]    = evt_full[n];
            evt_vec[n+16] = evt_half[n];
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ch_enable == '0 && ch_irq == '0 && wdt_stop && flag_q == '0));

    a_r2_enable_set: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == 8'h14) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_enable_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == 8'h18) |=> ((en_q & $past(bus_wdata)) == '0));

    a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
        (evt_vec != '0) |=> ((flag_q & $past(evt_vec)) == $past(evt_vec)));

    a_r7_all_masked: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> (ch_irq == '0));

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr_en && evt_vec == '0) |=>
            ($stable(en_q) && $stable(stop_q) && $stable(flag_q) && $stable(mask_q)));
endmodule

bind tcu_ctrl_bank tcu_ctrl_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_full  (evt_full),
    .evt_half  (evt_half),
    .ch_irq    (ch_irq),
    .ch_enable (ch_enable),
    .wdt_stop  (wdt_stop),
    .en_q      (en_q),
    .stop_q    (stop_q),
    .flag_q    (flag_q),
    .mask_q    (mask_q)
);

// File: tb/tcu_ctrl_bank_tb.sv
module tcu_ctrl_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] expect_rd;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{8'h14, 32'h0000_0005, 8'h10, 32'h0000_0005},
        '{8'h14, 32'h0000_0002, 8'h10, 32'h0000_0007},
        '{8'h18, 32'h0000_0001, 8'h10, 32'h0000_0006},
        '{8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0006},
        '{8'h3C, 32'h0001_0003, 8'h1C, 32'hFFFE_FFFC},
        '{8'h2C, 32'h0000_0001, 8'h1C, 32'hFFFE_FFFD},
        '{8'h38, 32'h0001_0001, 8'h30, 32'hFFFE_FFFE},
        '{8'h34, 32'h0000_0001, 8'h30, 32'hFFFE_FFFF},
        '{8'h24, 32'h0003_0000, 8'h20, 32'h0003_0000},
        '{8'h28, 32'h0001_0000, 8'h20, 32'h0002_0000},
        '{8'h40, 32'h0000_1234, 8'h40, 32'h0000_0000},
        '{8'h28, 32'hFFFF_FFFF, 8'h20, 32'h0000_0000}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr_en = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  evt_full = '0;
    logic [NCH-1:0]  evt_half = '0;
    logic [NCH-1:0]  ch_irq, ch_enable, ch_stop;
    logic            wdt_stop;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcu_ctrl_bank #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .evt_full(evt_full), .evt_half(evt_half),
        .ch_irq(ch_irq), .ch_enable(ch_enable), .ch_stop(ch_stop),
        .wdt_stop(wdt_stop)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [NCH-1:0] ef, input logic [NCH-1:0] eh);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        evt_full = ef; evt_half = eh;
        @(posedge clk);
        #1;
        bus_wr_en = 1'b0; evt_full = '0; evt_half = '0;
    endtask

    task automatic pulse_events(input logic [NCH-1:0] ef, input logic [NCH-1:0] eh);
        @(negedge clk);
        evt_full = ef; evt_half = eh;
        @(posedge clk);
        #1;
        evt_full = '0; evt_half = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        bus_read(8'h10, rd); check("R1 enable word", rd, 32'h0);
        bus_read(8'h1C, rd); check("R1 stop word", rd, 32'hFFFF_FFFF);
        bus_read(8'h20, rd); check("R1 flag word", rd, 32'h0);
        bus_read(8'h30, rd); check("R1 mask word", rd, 32'hFFFF_FFFF);
        check("R1 irq", 32'(ch_irq), 32'h0);
        check("R1 wdt_stop", 32'(wdt_stop), 32'h1);

        // R2 R3 R4: alias table walk
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].waddr, VECS[i].wdata, '0, '0);
            bus_read(VECS[i].raddr, rd);
            check($sformatf("R2 R3 R4 table vec %0d", i), rd, VECS[i].expect_rd);
        end

        // R8: channel outputs follow enable 0x6 and stop 0xFFFEFFFD
        check("R8 ch_enable", 32'(ch_enable), 32'h6);
        check("R8 ch_stop", 32'(ch_stop), 32'hD);
        check("R8 wdt_stop", 32'(wdt_stop), 32'h0);

        // R5 R7: half event ch0 with half mask open
        pulse_events(4'b0000, 4'b0001);
        bus_read(8'h20, rd); check("R5 half flag ch0", rd, 32'h0001_0000);
        check("R7 irq half unmasked", 32'(ch_irq), 32'h1);

        // R5 R7: full event ch2 while masked
        pulse_events(4'b0100, 4'b0000);
        bus_read(8'h20, rd); check("R5 full flag ch2", rd, 32'h0001_0004);
        check("R7 irq masked full", 32'(ch_irq), 32'h1);
        bus_write(8'h38, 32'h4, '0, '0);
        #1; check("R7 irq after unmask", 32'(ch_irq), 32'h5);

        // R6: clear-all write together with full event ch3
        bus_write(8'h28, 32'hFFFF_FFFF, 4'b1000, 4'b0000);
        bus_read(8'h20, rd); check("R6 event beats clear", rd, 32'h0000_0008);
        check("R6 R7 irq after collision", 32'(ch_irq), 32'h0);

        // R9: idle cycles leave state untouched
        repeat (5) @(posedge clk);
        bus_read(8'h10, rd); check("R9 enable idle", rd, 32'h6);
        bus_read(8'h20, rd); check("R9 flag idle", rd, 32'h8);
        bus_read(8'h30, rd); check("R9 mask idle", rd, 32'hFFFE_FFFB);

        finish_run();
    end
endmodule